// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a small presettable binary counter with two count strobes: one steps the count up and the other steps it down. The strobes are treated as slow external waveforms. A fast system clock samples each one through a synchronizer, and only a rising edge on one strobe, seen while the other strobe sits high, moves the count by one. A level-active clear forces the count to zero, and an active-low load copies a data word into the count. Both take effect on the visible count at once, whatever the strobes are doing.

Two active-low terminal-count outputs support cascading. The up terminal output follows the synchronized up strobe while the count is at its maximum value, and the down terminal output follows the synchronized down strobe while the count is zero. Each one can feed the matching strobe of a higher-order stage. Counting wraps in both directions. A strobe held low through a clear or load is still counted when it rises after the release.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising edge on `up_i` while `dn_i` is high adds one to the count. The new value appears on `count_o` at the third rising clock edge after `up_i` rises.
- R2: A rising edge on `dn_i` while `up_i` is high subtracts one from the count, with the same latency as R1.
- R3: Counting wraps modulo 2^WIDTH. Counting up from all ones gives zero, and counting down from zero gives all ones.
- R4: The count is unchanged when both strobes rise in the same sampled cycle, or when a strobe rises while the other strobe is low.
- R5: While `load_n_i` is low and `clr_i` is low, `count_o` equals `data_i`, whatever the strobes do. After release the loaded value stays, and strobe edges seen during the load are not counted.
- R6: While `clr_i` is high, `count_o` is zero. Clear wins over an active load and over both strobes.
- R7: A strobe held low through a clear or a load is counted on its first rise after the release.
- R8: `tc_up_n_o` is low exactly when the count is all ones and the synchronized up strobe is low. Otherwise it is high.
- R9: `tc_dn_n_o` is low exactly when the count is zero and the synchronized down strobe is low. Otherwise it is high.
- R10: After synchronous reset, with both strobes held high, the count is zero and both terminal outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset |
| up_i | input | 1 | Count-up strobe, idle high |
| dn_i | input | 1 | Count-down strobe, idle high |
| load_n_i | input | 1 | Parallel load, active low, level |
| clr_i | input | 1 | Clear, active high, level |
| data_i | input | WIDTH | Value to load |
| count_o | output | WIDTH | Current count |
| tc_up_n_o | output | 1 | Up terminal count, active low |
| tc_dn_n_o | output | 1 | Down terminal count, active low |

## Verification
The bench drives single up and down pulses from a loaded mid-range value. These separate the two directions and check the step size. Loads of the extreme values, followed by strobe pulses, exercise both wrap points and show the terminal outputs tracking the strobe only at those counts. Illegal pairs are applied: simultaneous rises, and a rise while the other strobe is low. They must leave the count frozen, and a later legal rise on the held strobe must still count. Clear asserted together with load, and strobes held low through clear or load, show the override order and that a pending rise survives the release.

// File: rtl/udc_pkg.sv
package udc_pkg;

    // Level or edge information for the two strobes, one bit each
    typedef struct packed {
        logic up;
        logic dn;
    } strobe_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    // A strobe edge counts only when it is alone and the other strobe is high
    function automatic step_e decode_step(strobe_t lvl, strobe_t rise);
        step_e s;
        s = STEP_HOLD;
        if (rise.up && !rise.dn && lvl.dn)
            s = STEP_INC;
        else if (rise.dn && !rise.up && lvl.up)
            s = STEP_DEC;
        return s;
    endfunction

endpackage

// File: rtl/udc_strobe_sync.sv
module udc_strobe_sync
    import udc_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t raw_i,
    output strobe_t lvl_o,
    output strobe_t rise_o
);
    localparam int unsigned NCH = 2;

    logic [NCH-1:0] raw_vec;
    logic [NCH-1:0] lvl_vec;
    logic [NCH-1:0] prev_q;

    assign raw_vec = raw_i;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [STAGES-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '1;
            else     sh_q <= {sh_q[STAGES-2:0], raw_vec[c]};
        end
        assign lvl_vec[c] = sh_q[STAGES-1];
    end

    // The previous sample keeps tracking during clear and load
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= lvl_vec;
    end

    assign lvl_o  = lvl_vec;
    assign rise_o = lvl_vec & ~prev_q;

    // R1
    rise_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o.up |=> !rise_o.up);

endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
    import udc_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] data_i,
    input  step_e            step_i,
    output logic [WIDTH-1:0] count_o
);
    localparam logic [WIDTH-1:0] CNT_MAX  = '1;
    localparam logic [WIDTH-1:0] CNT_ZERO = '0;

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= CNT_ZERO;
        else if (!load_n_i)
            cnt_q <= data_i;
        else begin
            case (step_i)
                STEP_INC: cnt_q <= cnt_q + 1'b1;
                STEP_DEC: cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // Clear and load override the stored value at once on the output
    always_comb begin
        if (clr_i)          count_o = CNT_ZERO;
        else if (!load_n_i) count_o = data_i;
        else                count_o = cnt_q;
    end

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == CNT_ZERO);

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !load_n_i) |=> cnt_q == $past(data_i));

    // R3
    wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && load_n_i && step_i == STEP_INC && cnt_q == CNT_MAX)
        |=> cnt_q == CNT_ZERO);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && load_n_i && step_i == STEP_HOLD) |=> $stable(cnt_q));

endmodule

// File: rtl/udc_term_gen.sv
module udc_term_gen
    import udc_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] count_i,
    input  strobe_t          lvl_i,
    output logic             tc_up_n_o,
    output logic             tc_dn_n_o
);
    localparam logic [WIDTH-1:0] CNT_MAX  = '1;
    localparam logic [WIDTH-1:0] CNT_ZERO = '0;

    // Each output copies its strobe only at the matching end of the range
    assign tc_up_n_o = !((count_i == CNT_MAX)  && !lvl_i.up);
    assign tc_dn_n_o = !((count_i == CNT_ZERO) && !lvl_i.dn);

endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
    import udc_pkg::*;
#(
    parameter int unsigned WIDTH       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             load_n_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             tc_up_n_o,
    output logic             tc_dn_n_o
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    strobe_t raw, lvl, rise;
    step_e   step;

    assign raw.up = up_i;
    assign raw.dn = dn_i;

    udc_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    assign step = decode_step(lvl, rise);

    udc_count_core #(.WIDTH(WIDTH)) i_core (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr_i),
        .load_n_i (load_n_i),
        .data_i   (data_i),
        .step_i   (step),
        .count_o  (count_o)
    );

    udc_term_gen #(.WIDTH(WIDTH)) i_term (
        .count_i   (count_o),
        .lvl_i     (lvl),
        .tc_up_n_o (tc_up_n_o),
        .tc_dn_n_o (tc_dn_n_o)
    );

    // R8
    tc_up_only_at_max_chk: assert property (@(posedge clk) disable iff (rst)
        !tc_up_n_o |-> count_o == CNT_MAX);

    // R9
    tc_dn_only_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !tc_dn_n_o |-> count_o == '0);

endmodule

// File: tb/test_dual_strobe_counter.sv
module test_dual_strobe_counter;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         up_i = 1'b1, dn_i = 1'b1, load_n_i = 1'b1, clr_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic [W-1:0] count_o;
    logic         tc_up_n_o, tc_dn_n_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dual_strobe_counter #(.WIDTH(W)) i_dual_strobe_counter (
        .clk(clk), .rst(rst), .up_i(up_i), .dn_i(dn_i),
        .load_n_i(load_n_i), .clr_i(clr_i), .data_i(data_i),
        .count_o(count_o), .tc_up_n_o(tc_up_n_o), .tc_dn_n_o(tc_dn_n_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] v);
        load_n_i = 1'b0; data_i = v;
        wait_cyc(2);
        load_n_i = 1'b1;
        wait_cyc(2);
    endtask

    task automatic pulse_up();
        up_i = 1'b0; wait_cyc(4);
        up_i = 1'b1; wait_cyc(4);
    endtask

    task automatic pulse_dn();
        dn_i = 1'b0; wait_cyc(4);
        dn_i = 1'b1; wait_cyc(4);
    endtask

    task automatic t_reset();
        chk(count_o == 0, "R10 count", count_o, 0);
        chk(tc_up_n_o && tc_dn_n_o, "R10 tc", {tc_up_n_o, tc_dn_n_o}, 3);
    endtask

    task automatic t_load();
        load_n_i = 1'b0; data_i = 4'd9;
        #1 chk(count_o == 9, "R5 immediate", count_o, 9);
        up_i = 1'b0; wait_cyc(4);
        up_i = 1'b1; wait_cyc(4);
        chk(count_o == 9, "R5 during load", count_o, 9);
        load_n_i = 1'b1; data_i = 4'd2; wait_cyc(4);
        chk(count_o == 9, "R5 after release", count_o, 9);
    endtask

    task automatic t_up_latency();
        up_i = 1'b0; wait_cyc(4);
        up_i = 1'b1;
        wait_cyc(2);
        chk(count_o == 9, "R1 before third edge", count_o, 9);
        wait_cyc(1);
        chk(count_o == 10, "R1 at third edge", count_o, 10);
        wait_cyc(3);
        pulse_up(); pulse_up();
        chk(count_o == 12, "R1 three ups", count_o, 12);
    endtask

    task automatic t_down();
        pulse_dn(); pulse_dn();
        chk(count_o == 10, "R2 two downs", count_o, 10);
    endtask

    task automatic t_wrap_up();
        do_load(4'd15);
        up_i = 1'b0; wait_cyc(4);
        chk(tc_up_n_o == 1'b0, "R8 low at max", tc_up_n_o, 0);
        chk(tc_dn_n_o == 1'b1, "R9 high off zero", tc_dn_n_o, 1);
        up_i = 1'b1; wait_cyc(4);
        chk(count_o == 0, "R3 wrap up", count_o, 0);
        chk(tc_up_n_o == 1'b1, "R8 high after wrap", tc_up_n_o, 1);
    endtask

    task automatic t_wrap_dn();
        dn_i = 1'b0; wait_cyc(4);
        chk(tc_dn_n_o == 1'b0, "R9 low at zero", tc_dn_n_o, 0);
        dn_i = 1'b1; wait_cyc(4);
        chk(count_o == 15, "R3 wrap down", count_o, 15);
        chk(tc_dn_n_o == 1'b1, "R9 high after wrap", tc_dn_n_o, 1);
        up_i = 1'b0; wait_cyc(4); up_i = 1'b1;
        do_load(4'd6);
        up_i = 1'b0; wait_cyc(4);
        chk(tc_up_n_o == 1'b1, "R8 high off max", tc_up_n_o, 1);
        up_i = 1'b1; wait_cyc(4);
    endtask

    task automatic t_illegal();
        do_load(4'd6);
        up_i = 1'b0; dn_i = 1'b0; wait_cyc(4);
        up_i = 1'b1; dn_i = 1'b1; wait_cyc(4);
        chk(count_o == 6, "R4 simultaneous", count_o, 6);
        dn_i = 1'b0; wait_cyc(4);
        pulse_up();
        chk(count_o == 6, "R4 up while down low", count_o, 6);
        dn_i = 1'b1; wait_cyc(4);
        chk(count_o == 5, "R2 down after illegal", count_o, 5);
    endtask

    task automatic t_clear();
        do_load(4'd7);
        clr_i = 1'b1; load_n_i = 1'b0; data_i = 4'd5;
        #1 chk(count_o == 0, "R6 immediate over load", count_o, 0);
        up_i = 1'b0; wait_cyc(4); up_i = 1'b1; wait_cyc(4);
        chk(count_o == 0, "R6 held", count_o, 0);
        load_n_i = 1'b1; clr_i = 1'b0; wait_cyc(3);
        chk(count_o == 0, "R6 after release", count_o, 0);
    endtask

    task automatic t_held_low();
        dn_i = 1'b0; wait_cyc(4);
        clr_i = 1'b1; wait_cyc(3);
        clr_i = 1'b0; wait_cyc(2);
        dn_i = 1'b1; wait_cyc(4);
        chk(count_o == 15, "R7 down after clear", count_o, 15);
        up_i = 1'b0; wait_cyc(4);
        load_n_i = 1'b0; data_i = 4'd3; wait_cyc(3);
        load_n_i = 1'b1; wait_cyc(2);
        up_i = 1'b1; wait_cyc(4);
        chk(count_o == 4, "R7 up after load", count_o, 4);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(3);
        t_reset();
        t_load();
        t_up_latency();
        t_down();
        t_wrap_up();
        t_wrap_dn();
        t_illegal();
        t_clear();
        t_held_low();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule